// File: doc/BRIEF.md
# PCI Function Slot Lifecycle Controller

This block keeps the lifecycle state of a small, fixed table of PCI function slots inside a host bridge. Each slot has a function identifier (FID) and is in one of five states: reserved, standby, disabled, enabled or blocked. Software and the hotplug path send one request per handshake: create, attach, configure, deconfigure, unplug, reset, enable or block. Each request names a FID. The block answers every accepted request with a 16-bit result code and a function handle. A handle holds the slot index in its low bits and the slot's enable flag in its top bit.

Some transitions announce themselves by pushing an availability event (code plus FID) into an external event FIFO. When an active function is unplugged, the slot is not removed at once. The block pushes a deconfigure-request event and starts a per-slot release countdown that is paced by an external tick. If software does not deconfigure the slot before the countdown runs out, the block forces the slot off and removes it.

The interrupt-registration and address-translation units sit outside the block. They report through level inputs whether each slot currently holds registrations. The block answers with one-cycle deregistration strobes.

Top module: `fcs_ctrl`

## Requirements
- R1: After reset the table is empty. Ready is high, and no response, event or strobe is driven. A request whose FID matches no occupied slot returns code 0x0040 with an all-zero handle.
- R2: Create (op 4) places the FID in the lowest-numbered free slot in the reserved state and returns 0x0010 with that slot index and enable flag 0. A FID already present returns 0x0080. A full table returns 0x0050. Both rejections carry a zero handle.
- R3: Configure (op 0) on a reserved slot returns 0x0030. On a standby slot it moves the slot to disabled and returns 0x0010. In disabled, enabled or blocked it returns 0x0020 and changes nothing.
- R4: Deconfigure (op 1) on a reserved slot returns 0x0030, and on a standby slot returns 0x0020. From disabled, enabled or blocked it moves the slot to standby, clears the enable flag and returns 0x0010.
- R5: A deconfigure that completes while the slot's release countdown is running also removes the slot. It pushes event 0x03 with the old FID and stops the countdown. The FID then no longer matches.
- R6: Unplug (op 2) on a disabled, enabled or blocked slot pushes event 0x01 with the FID, starts the release countdown at TMO_TICKS and returns 0x0070 with the current handle.
- R7: Once TMO_TICKS tick pulses have been counted, the slot is forced off. The block pushes event 0x02 with the FID, issues strobes for the slot's held registrations and removes the slot. Fewer ticks leave it untouched.
- R8: Unplug on a standby slot stops any countdown, pushes event 0x03 and removes the slot. Unplug on a reserved slot removes it with no event. Both return 0x0010 with enable flag 0.
- R9: Reset (op 3) on a reserved slot returns 0x0020 and does nothing else. On standby it returns 0x0010. On disabled, enabled or blocked it clears the enable flag, moves the slot to disabled and returns 0x0010.
- R10: Attach (op 5) moves reserved to standby. Enable (op 6) moves disabled to enabled and sets the enable flag. Block (op 7) moves enabled to blocked. Each returns 0x0010 on success and 0x0060 from any other state.
- R11: A response appears exactly one cycle after a request is accepted. Ready is low in every cycle in which a countdown has expired. An expiry is handled before a request that waits for it.
- R12: Deconfigure, reset (non-reserved) and forced-off strobe the interrupt and translation deregistration outputs of that one slot, each only if the matching hold input was high. Strobes appear in the cycle of the response or event they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_op_i | input | 3 | Request opcode |
| req_fid_i | input | FID_W | Target function identifier |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_code_o | output | 16 | Result code |
| rsp_handle_o | output | HANDLE_W | Function handle: top bit enable, low bits slot index |
| evt_valid_o | output | 1 | Event push strobe |
| evt_code_o | output | 8 | Event code |
| evt_fid_o | output | FID_W | FID carried by the event |
| tick_i | input | 1 | Release countdown tick |
| irq_reg_i | input | NUM_SLOTS | Slot holds interrupt registrations |
| xlat_on_i | input | NUM_SLOTS | Slot has translation enabled |
| irq_dereg_o | output | NUM_SLOTS | Deregister interrupts strobe per slot |
| xlat_off_o | output | NUM_SLOTS | Disable translation strobe per slot |

## Verification
A countdown expiry and a new request can fall due in the same cycle, and both want to write the slot table and the event port. The bench provokes this by arming one slot through unplug and supplying exactly TMO_TICKS ticks. In the very cycle the countdown reaches zero, it presents a configure aimed at a different slot. The scoreboard requires that ready is low in that cycle, that the forced-off event with its translation strobe comes out first, and that the configure response follows one cycle later with its own code.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    SL_RESERVED = 3'd0,
    SL_STANDBY  = 3'd1,
    SL_DISABLED = 3'd2,
    SL_ENABLED  = 3'd3,
    SL_BLOCKED  = 3'd4
  } slot_state_e;

  typedef enum logic [2:0] {
    OP_CONFIGURE   = 3'd0,
    OP_DECONFIGURE = 3'd1,
    OP_UNPLUG      = 3'd2,
    OP_RESET       = 3'd3,
    OP_CREATE      = 3'd4,
    OP_ATTACH      = 3'd5,
    OP_ENABLE      = 3'd6,
    OP_BLOCK       = 3'd7
  } fcs_op_e;

  localparam logic [15:0] RC_DONE      = 16'h0010;
  localparam logic [15:0] RC_NO_ACTION = 16'h0020;
  localparam logic [15:0] RC_RESERVED  = 16'h0030;
  localparam logic [15:0] RC_UNKNOWN   = 16'h0040;
  localparam logic [15:0] RC_FULL      = 16'h0050;
  localparam logic [15:0] RC_BAD_STATE = 16'h0060;
  localparam logic [15:0] RC_PENDING   = 16'h0070;
  localparam logic [15:0] RC_IN_USE    = 16'h0080;

  localparam logic [7:0] EV_DECONF_REQ  = 8'h01;
  localparam logic [7:0] EV_FORCED_OFF  = 8'h02;
  localparam logic [7:0] EV_STBY_TO_RES = 8'h03;

endpackage

// File: rtl/fcs_prio.sv
module fcs_prio #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/fcs_slot_timer.sv
module fcs_slot_timer #(
  parameter int TMO_TICKS = 4,
  parameter int CW        = $clog2(TMO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic cancel_i,
  output logic armed_o,
  output logic due_o
);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (cancel_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = CW'(TMO_TICKS);
    end else if (armed_q && tick_i && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign upd = cancel_i | arm_i | (armed_q & tick_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;
  assign due_o   = armed_q && (cnt_q == '0);

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int FID_W     = 8,
  parameter int HANDLE_W  = 16,
  parameter int TMO_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [2:0]           req_op_i,
  input  logic [FID_W-1:0]     req_fid_i,
  output logic                 rsp_valid_o,
  output logic [15:0]          rsp_code_o,
  output logic [HANDLE_W-1:0]  rsp_handle_o,
  output logic                 evt_valid_o,
  output logic [7:0]           evt_code_o,
  output logic [FID_W-1:0]     evt_fid_o,
  input  logic                 tick_i,
  input  logic [NUM_SLOTS-1:0] irq_reg_i,
  input  logic [NUM_SLOTS-1:0] xlat_on_i,
  output logic [NUM_SLOTS-1:0] irq_dereg_o,
  output logic [NUM_SLOTS-1:0] xlat_off_o
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  slot_state_e         st_q  [NUM_SLOTS];
  slot_state_e         st_d  [NUM_SLOTS];
  logic [FID_W-1:0]    fid_q [NUM_SLOTS];
  logic [FID_W-1:0]    fid_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] used_q, used_d, en_q, en_d;

  logic [NUM_SLOTS-1:0] match_v, free_v, due_v, armed_v, arm_v, cancel_v;
  logic                 hit, free_any, due_any;
  logic [IDX_W-1:0]     h, free_idx, due_idx;

  logic                 rsp_v_d, evt_v_d;
  logic [15:0]          rsp_code_d;
  logic [HANDLE_W-1:0]  rsp_h_d;
  logic [7:0]           evt_code_d;
  logic [FID_W-1:0]     evt_fid_d;
  logic [NUM_SLOTS-1:0] irq_d, xlat_d;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign match_v[g] = used_q[g] && (fid_q[g] == req_fid_i);
    assign free_v[g]  = ~used_q[g];
    fcs_slot_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .arm_i(arm_v[g]), .cancel_i(cancel_v[g]),
      .armed_o(armed_v[g]), .due_o(due_v[g])
    );
  end

  fcs_prio #(.N(NUM_SLOTS), .W(IDX_W)) u_hit  (.req_i(match_v), .any_o(hit),      .idx_o(h));
  fcs_prio #(.N(NUM_SLOTS), .W(IDX_W)) u_free (.req_i(free_v),  .any_o(free_any), .idx_o(free_idx));
  fcs_prio #(.N(NUM_SLOTS), .W(IDX_W)) u_due  (.req_i(due_v),   .any_o(due_any),  .idx_o(due_idx));

  assign req_ready_o = ~due_any;

  function automatic logic [HANDLE_W-1:0] mk_handle(input logic en, input logic [IDX_W-1:0] idx);
    logic [HANDLE_W-1:0] r;
    r = '0;
    r[HANDLE_W-1] = en;
    r[IDX_W-1:0]  = idx;
    return r;
  endfunction

  always_comb begin
    st_d = st_q; fid_d = fid_q; used_d = used_q; en_d = en_q;
    rsp_v_d = 1'b0; rsp_code_d = '0; rsp_h_d = '0;
    evt_v_d = 1'b0; evt_code_d = '0; evt_fid_d = '0;
    irq_d = '0; xlat_d = '0; arm_v = '0; cancel_v = '0;
    if (due_any) begin
      // forced release after countdown expiry
      irq_d[due_idx]    = irq_reg_i[due_idx];
      xlat_d[due_idx]   = xlat_on_i[due_idx];
      evt_v_d           = 1'b1;
      evt_code_d        = EV_FORCED_OFF;
      evt_fid_d         = fid_q[due_idx];
      cancel_v[due_idx] = 1'b1;
      used_d[due_idx] = 1'b0; fid_d[due_idx] = '0;
      st_d[due_idx]   = SL_RESERVED; en_d[due_idx] = 1'b0;
    end else if (req_valid_i) begin
      rsp_v_d = 1'b1;
      if (fcs_op_e'(req_op_i) == OP_CREATE) begin
        if (hit)            rsp_code_d = RC_IN_USE;
        else if (!free_any) rsp_code_d = RC_FULL;
        else begin
          rsp_code_d = RC_DONE;
          rsp_h_d    = mk_handle(1'b0, free_idx);
          used_d[free_idx] = 1'b1; fid_d[free_idx] = req_fid_i;
          st_d[free_idx]   = SL_RESERVED; en_d[free_idx] = 1'b0;
        end
      end else if (!hit) begin
        rsp_code_d = RC_UNKNOWN;
      end else begin
        rsp_h_d = mk_handle(en_q[h], h);
        unique case (fcs_op_e'(req_op_i))
          OP_CONFIGURE: begin
            if (st_q[h] == SL_RESERVED)     rsp_code_d = RC_RESERVED;
            else if (st_q[h] == SL_STANDBY) begin
              rsp_code_d = RC_DONE; st_d[h] = SL_DISABLED;
            end else                        rsp_code_d = RC_NO_ACTION;
          end
          OP_DECONFIGURE: begin
            if (st_q[h] == SL_RESERVED)     rsp_code_d = RC_RESERVED;
            else if (st_q[h] == SL_STANDBY) rsp_code_d = RC_NO_ACTION;
            else begin
              rsp_code_d = RC_DONE;
              rsp_h_d    = mk_handle(1'b0, h);
              irq_d[h]   = irq_reg_i[h];
              xlat_d[h]  = xlat_on_i[h];
              st_d[h]    = SL_STANDBY; en_d[h] = 1'b0;
              if (armed_v[h]) begin
                evt_v_d = 1'b1; evt_code_d = EV_STBY_TO_RES; evt_fid_d = fid_q[h];
                cancel_v[h] = 1'b1;
                used_d[h] = 1'b0; fid_d[h] = '0; st_d[h] = SL_RESERVED;
              end
            end
          end
          OP_UNPLUG: begin
            if (st_q[h] == SL_RESERVED || st_q[h] == SL_STANDBY) begin
              rsp_code_d  = RC_DONE;
              rsp_h_d     = mk_handle(1'b0, h);
              cancel_v[h] = 1'b1;
              if (st_q[h] == SL_STANDBY) begin
                evt_v_d = 1'b1; evt_code_d = EV_STBY_TO_RES; evt_fid_d = fid_q[h];
              end
              used_d[h] = 1'b0; fid_d[h] = '0; st_d[h] = SL_RESERVED; en_d[h] = 1'b0;
            end else begin
              rsp_code_d = RC_PENDING;
              arm_v[h]   = 1'b1;
              evt_v_d = 1'b1; evt_code_d = EV_DECONF_REQ; evt_fid_d = fid_q[h];
            end
          end
          OP_RESET: begin
            if (st_q[h] == SL_RESERVED) rsp_code_d = RC_NO_ACTION;
            else begin
              rsp_code_d = RC_DONE;
              irq_d[h]   = irq_reg_i[h];
              xlat_d[h]  = xlat_on_i[h];
              if (st_q[h] != SL_STANDBY) begin
                st_d[h] = SL_DISABLED; en_d[h] = 1'b0;
                rsp_h_d = mk_handle(1'b0, h);
              end
            end
          end
          OP_ATTACH: begin
            if (st_q[h] == SL_RESERVED) begin
              rsp_code_d = RC_DONE; st_d[h] = SL_STANDBY;
            end else rsp_code_d = RC_BAD_STATE;
          end
          OP_ENABLE: begin
            if (st_q[h] == SL_DISABLED) begin
              rsp_code_d = RC_DONE; st_d[h] = SL_ENABLED; en_d[h] = 1'b1;
              rsp_h_d    = mk_handle(1'b1, h);
            end else rsp_code_d = RC_BAD_STATE;
          end
          default: begin
            if (st_q[h] == SL_ENABLED) begin
              rsp_code_d = RC_DONE; st_d[h] = SL_BLOCKED;
            end else rsp_code_d = RC_BAD_STATE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        st_q[i]  <= SL_RESERVED;
        fid_q[i] <= '0;
      end
      used_q <= '0; en_q <= '0;
      rsp_valid_o <= 1'b0; rsp_code_o <= '0; rsp_handle_o <= '0;
      evt_valid_o <= 1'b0; evt_code_o <= '0; evt_fid_o <= '0;
      irq_dereg_o <= '0; xlat_off_o <= '0;
    end else begin
      st_q <= st_d; fid_q <= fid_d; used_q <= used_d; en_q <= en_d;
      rsp_valid_o  <= rsp_v_d;
      rsp_code_o   <= rsp_code_d;
      rsp_handle_o <= rsp_h_d;
      evt_valid_o  <= evt_v_d;
      evt_code_o   <= evt_code_d;
      evt_fid_o    <= evt_fid_d;
      irq_dereg_o  <= irq_d;
      xlat_off_o   <= xlat_d;
    end
  end

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int FID_W     = 8,
  parameter int HANDLE_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 rsp_valid_o,
  input logic [15:0]          rsp_code_o,
  input logic [HANDLE_W-1:0]  rsp_handle_o,
  input logic                 evt_valid_o,
  input logic [NUM_SLOTS-1:0] irq_reg_i,
  input logic [NUM_SLOTS-1:0] xlat_on_i,
  input logic [NUM_SLOTS-1:0] irq_dereg_o,
  input logic [NUM_SLOTS-1:0] xlat_off_o
);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R11

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o)); // R11

  AST_UNKNOWN_ZERO_HANDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_code_o == RC_UNKNOWN) |-> (rsp_handle_o == '0)); // R1

  AST_IRQ_STRB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dereg_o & ~$past(irq_reg_i)) == '0); // R12

  AST_XLAT_STRB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_off_o & ~$past(xlat_on_i)) == '0); // R12

  AST_STRB_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_dereg_o | xlat_off_o)); // R12

  AST_STRB_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_dereg_o) || (|xlat_off_o)) |-> (rsp_valid_o || evt_valid_o)); // R12

endmodule

bind fcs_ctrl fcs_checker #(
  .NUM_SLOTS(NUM_SLOTS), .FID_W(FID_W), .HANDLE_W(HANDLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o), .rsp_handle_o(rsp_handle_o),
  .evt_valid_o(evt_valid_o), .irq_reg_i(irq_reg_i), .xlat_on_i(xlat_on_i),
  .irq_dereg_o(irq_dereg_o), .xlat_off_o(xlat_off_o)
);

// File: tb/fcs_ctrl_tb.sv
module fcs_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int FW  = 8;
  localparam int HW  = 16;
  localparam int TMO = 4;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [2:0]    req_op;
  logic [FW-1:0] req_fid;
  logic          rsp_valid;
  logic [15:0]   rsp_code;
  logic [HW-1:0] rsp_handle;
  logic          evt_valid;
  logic [7:0]    evt_code;
  logic [FW-1:0] evt_fid;
  logic          tick;
  logic [N-1:0]  irq_reg, xlat_on, irq_dereg, xlat_off;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic        is_evt;
    logic [15:0] code;
    logic [15:0] aux;
    logic        chk_strb;
    logic [N-1:0] irq;
    logic [N-1:0] xlat;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  fcs_ctrl #(.NUM_SLOTS(N), .FID_W(FW), .HANDLE_W(HW), .TMO_TICKS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_fid_i(req_fid), .rsp_valid_o(rsp_valid),
    .rsp_code_o(rsp_code), .rsp_handle_o(rsp_handle), .evt_valid_o(evt_valid),
    .evt_code_o(evt_code), .evt_fid_o(evt_fid), .tick_i(tick),
    .irq_reg_i(irq_reg), .xlat_on_i(xlat_on), .irq_dereg_o(irq_dereg),
    .xlat_off_o(xlat_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // scoreboard monitor: compares design output with expected queue
  task automatic take(input bit is_evt);
    item_t e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R11", is_evt ? "unexpected event" : "unexpected response",
            is_evt ? 32'(evt_code) : 32'(rsp_code), 32'h0);
      return;
    end
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(e.is_evt == is_evt, t, "item kind", 32'(is_evt), 32'(e.is_evt));
    if (is_evt) begin
      check(evt_code == e.code[7:0] && evt_fid == e.aux[FW-1:0], t, "event code/fid",
            {16'(evt_code), 16'(evt_fid)}, {16'(e.code[7:0]), 16'(e.aux[FW-1:0])});
    end else begin
      check(rsp_code == e.code && rsp_handle == e.aux, t, "response code/handle",
            {rsp_code, rsp_handle}, {e.code, e.aux});
    end
    if (e.chk_strb)
      check(irq_dereg == e.irq && xlat_off == e.xlat, t, "strobes irq/xlat",
            {16'(irq_dereg), 16'(xlat_off)}, {16'(e.irq), 16'(e.xlat)});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (evt_valid) take(1'b1);
        if (rsp_valid) take(1'b0);
      end
    end
  end

  task automatic exp_evt(input logic [7:0] code, input logic [FW-1:0] fid, input bit strb,
                         input logic [N-1:0] irq, input logic [N-1:0] xl, input string tag);
    item_t e;
    e = '{is_evt: 1'b1, code: 16'(code), aux: 16'(fid), chk_strb: strb, irq: irq, xlat: xl};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // driver: called just after a falling edge, returns just after a falling edge
  task automatic req(input logic [2:0] op, input logic [FW-1:0] fid, input logic [15:0] code,
                     input logic [HW-1:0] hnd, input logic [N-1:0] irq, input logic [N-1:0] xl,
                     input string tag);
    item_t e;
    e = '{is_evt: 1'b0, code: code, aux: hnd, chk_strb: 1'b1, irq: irq, xlat: xl};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_op = op; req_fid = fid;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_fid = '0;
    tick = 1'b0; irq_reg = '0; xlat_on = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    check(!rsp_valid && !evt_valid && irq_dereg == '0 && xlat_off == '0, "R1", "idle outputs",
          {30'h0, rsp_valid, evt_valid}, 32'h0);
    req(3'd0, 8'h05, 16'h0040, 16'h0000, 4'b0, 4'b0, "R1");

    // R2 creation
    req(3'd4, 8'h11, 16'h0010, 16'h0000, 4'b0, 4'b0, "R2");
    req(3'd4, 8'h22, 16'h0010, 16'h0001, 4'b0, 4'b0, "R2");
    req(3'd4, 8'h11, 16'h0080, 16'h0000, 4'b0, 4'b0, "R2");
    req(3'd4, 8'h33, 16'h0010, 16'h0002, 4'b0, 4'b0, "R2");
    req(3'd4, 8'h44, 16'h0010, 16'h0003, 4'b0, 4'b0, "R2");
    req(3'd4, 8'h55, 16'h0050, 16'h0000, 4'b0, 4'b0, "R2");

    // reserved-state answers
    req(3'd0, 8'h11, 16'h0030, 16'h0000, 4'b0, 4'b0, "R3");
    req(3'd1, 8'h11, 16'h0030, 16'h0000, 4'b0, 4'b0, "R4");
    irq_reg = 4'b0001; xlat_on = 4'b0001;
    req(3'd3, 8'h11, 16'h0020, 16'h0000, 4'b0, 4'b0, "R9");
    req(3'd6, 8'h11, 16'h0060, 16'h0000, 4'b0, 4'b0, "R10");

    // bring slot 0 up
    req(3'd5, 8'h11, 16'h0010, 16'h0000, 4'b0, 4'b0, "R10");
    req(3'd0, 8'h11, 16'h0010, 16'h0000, 4'b0, 4'b0, "R3");
    req(3'd0, 8'h11, 16'h0020, 16'h0000, 4'b0, 4'b0, "R3");
    req(3'd6, 8'h11, 16'h0010, 16'h8000, 4'b0, 4'b0, "R10");
    req(3'd7, 8'h11, 16'h0010, 16'h8000, 4'b0, 4'b0, "R10");
    req(3'd7, 8'h11, 16'h0060, 16'h8000, 4'b0, 4'b0, "R10");
    req(3'd0, 8'h11, 16'h0020, 16'h8000, 4'b0, 4'b0, "R3");
    xlat_on = 4'b0000;
    req(3'd3, 8'h11, 16'h0010, 16'h0000, 4'b0001, 4'b0000, "R9");
    req(3'd6, 8'h11, 16'h0010, 16'h8000, 4'b0, 4'b0, "R9");

    // deconfigure and reset from standby
    xlat_on = 4'b0001;
    req(3'd1, 8'h11, 16'h0010, 16'h0000, 4'b0001, 4'b0001, "R4");
    req(3'd1, 8'h11, 16'h0020, 16'h0000, 4'b0, 4'b0, "R4");
    irq_reg = 4'b0000;
    req(3'd3, 8'h11, 16'h0010, 16'h0000, 4'b0000, 4'b0001, "R9");
    req(3'd0, 8'h11, 16'h0010, 16'h0000, 4'b0, 4'b0, "R3");
    xlat_on = 4'b0000;

    // R6 unplug of an active slot arms the countdown
    req(3'd5, 8'h22, 16'h0010, 16'h0001, 4'b0, 4'b0, "R10");
    req(3'd0, 8'h22, 16'h0010, 16'h0001, 4'b0, 4'b0, "R3");
    req(3'd6, 8'h22, 16'h0010, 16'h8001, 4'b0, 4'b0, "R10");
    exp_evt(8'h01, 8'h22, 1'b0, 4'b0, 4'b0, "R6");
    req(3'd2, 8'h22, 16'h0070, 16'h8001, 4'b0, 4'b0, "R6");
    ticks(TMO - 1);

    // R5 deconfigure while the countdown runs
    req(3'd5, 8'h33, 16'h0010, 16'h0002, 4'b0, 4'b0, "R10");
    req(3'd0, 8'h33, 16'h0010, 16'h0002, 4'b0, 4'b0, "R3");
    exp_evt(8'h01, 8'h33, 1'b0, 4'b0, 4'b0, "R6");
    req(3'd2, 8'h33, 16'h0070, 16'h0002, 4'b0, 4'b0, "R6");
    exp_evt(8'h03, 8'h33, 1'b0, 4'b0, 4'b0, "R5");
    req(3'd1, 8'h33, 16'h0010, 16'h0002, 4'b0, 4'b0, "R5");
    req(3'd0, 8'h33, 16'h0040, 16'h0000, 4'b0, 4'b0, "R5");

    // R7 last tick expires slot 1 (any early event would fail above)
    irq_reg = 4'b0010;
    exp_evt(8'h02, 8'h22, 1'b1, 4'b0010, 4'b0000, "R7");
    ticks(1);
    repeat (3) @(negedge clk);
    irq_reg = 4'b0000;
    req(3'd0, 8'h22, 16'h0040, 16'h0000, 4'b0, 4'b0, "R7");

    // R11 expiry and request in the same cycle
    req(3'd4, 8'h66, 16'h0010, 16'h0001, 4'b0, 4'b0, "R2");
    req(3'd5, 8'h66, 16'h0010, 16'h0001, 4'b0, 4'b0, "R10");
    req(3'd0, 8'h66, 16'h0010, 16'h0001, 4'b0, 4'b0, "R3");
    exp_evt(8'h01, 8'h66, 1'b0, 4'b0, 4'b0, "R6");
    req(3'd2, 8'h66, 16'h0070, 16'h0001, 4'b0, 4'b0, "R6");
    xlat_on = 4'b0010;
    exp_evt(8'h02, 8'h66, 1'b1, 4'b0000, 4'b0010, "R11");
    ticks(TMO);
    check(req_ready == 1'b0, "R11", "ready low on expiry", 32'(req_ready), 32'h0);
    req(3'd0, 8'h11, 16'h0020, 16'h0000, 4'b0, 4'b0, "R11");
    xlat_on = 4'b0000;

    // R8 unplug from reserved and from standby
    req(3'd2, 8'h44, 16'h0010, 16'h0003, 4'b0, 4'b0, "R8");
    req(3'd0, 8'h44, 16'h0040, 16'h0000, 4'b0, 4'b0, "R8");
    req(3'd4, 8'h77, 16'h0010, 16'h0001, 4'b0, 4'b0, "R2");
    req(3'd5, 8'h77, 16'h0010, 16'h0001, 4'b0, 4'b0, "R10");
    exp_evt(8'h03, 8'h77, 1'b0, 4'b0, 4'b0, "R8");
    req(3'd2, 8'h77, 16'h0010, 16'h0001, 4'b0, 4'b0, "R8");
    req(3'd0, 8'h77, 16'h0040, 16'h0000, 4'b0, 4'b0, "R8");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R11", "expected items left", 32'(exp_q.size()), 32'h0);
    summary();
    $finish;
  end

endmodule